// File: doc/BRIEF.md
# Bitwise and Logical-Shift Execution Unit

This combinational unit produces the result of the bitwise and logical-shift instructions of a 32-bit integer datapath. Each cycle it receives two register operands, a 16-bit instruction constant, a 5-bit shift count and a 4-bit operation code. It returns one 32-bit word. Nothing is stored, so the result follows the inputs within the same cycle.

Register-register forms apply AND, OR, NOR or XOR to the two operands. Each result bit depends only on the matching pair of operand bits, with no carry between positions. Constant forms combine the first operand with the zero-extended constant. Load-upper places the constant in the upper half of the word and clears the lower half, so that load-upper followed by OR-constant can build any 32-bit value. The two shifts move the first operand left or right and fill the vacated positions with zeros. An unassigned operation code produces zero and raises an illegal-operation flag.

Top module: `logic_shift_unit`

## Requirements
- R1: Op codes 0 (AND), 1 (OR) and 3 (XOR) return the bitwise AND, OR or XOR of `src_a` and `src_b`. Each bit is independent of the others, so 1 OR 1 gives 1 with no carry.
- R2: Op code 2 (NOR) returns the bitwise inverse of (`src_a` OR `src_b`).
- R3: Op code 9 (load-upper) returns `imm16` in bits 31..16 and zero in bits 15..0, and ignores `src_a`, `src_b` and `shamt`.
- R4: Op codes 4 (AND-const), 5 (OR-const) and 6 (XOR-const) combine `src_a` with `imm16` zero-extended to 32 bits. `src_b` is ignored.
- R5: Op code 8 (shift right) moves `src_a` toward bit 0 by `shamt` places and fills the upper bits with zeros. For example, 0x00000057 shifted right by 3 gives 0x0000000A.
- R6: Op code 7 (shift left) moves `src_a` toward bit 31 by `shamt` places and fills the lower bits with zeros.
- R7: Load-upper with 0x49B1, followed by OR-const with 0xAE09 applied to that result, yields 0x49B1AE09.
- R8: Op codes 10 through 15 return zero with `illegal_op` at 1. Op codes 0 through 9 drive `illegal_op` to 0.
- R9: Either shift with a `shamt` of 0 returns `src_a` unchanged. All counts from 0 to 31 are valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 32 | First register operand; the value that is shifted |
| src_b | input | 32 | Second register operand |
| imm16 | input | 16 | Instruction constant |
| shamt | input | 5 | Unsigned shift count |
| op_code | input | 4 | Operation select |
| result | output | 32 | Operation result |
| illegal_op | output | 1 | High when op_code is unassigned |

## Verification
The bitwise operations are driven with disjoint, complementary, all-ones and sparse high/low patterns. These separate AND, OR, NOR and XOR from one another, and show that OR is not addition. The constant forms use operands with a full upper half, so a sign-extended or truncated constant produces a visible difference. Both shifts are swept across every count with a pattern that has both end bits set. This exposes a wrong stage weight, a missing fill or a swapped direction. Load-upper and the constant-building pair are run with `src_a` and `src_b` held at all ones, which shows that those inputs are ignored.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_AND  = 4'd0;
  localparam logic [OP_W-1:0] OP_OR   = 4'd1;
  localparam logic [OP_W-1:0] OP_NOR  = 4'd2;
  localparam logic [OP_W-1:0] OP_XOR  = 4'd3;
  localparam logic [OP_W-1:0] OP_ANDI = 4'd4;
  localparam logic [OP_W-1:0] OP_ORI  = 4'd5;
  localparam logic [OP_W-1:0] OP_XORI = 4'd6;
  localparam logic [OP_W-1:0] OP_SLL  = 4'd7;
  localparam logic [OP_W-1:0] OP_SRL  = 4'd8;
  localparam logic [OP_W-1:0] OP_LUI  = 4'd9;

  typedef enum logic [1:0] {
    BK_AND = 2'd0,
    BK_OR  = 2'd1,
    BK_NOR = 2'd2,
    BK_XOR = 2'd3
  } bit_kind_e;

endpackage

// File: rtl/lsu_bitwise.sv
module lsu_bitwise
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  bit_kind_e         kind,
  output logic [DATA_W-1:0] res
);

  // One bit pair in, one bit out: no interaction between positions.
  function automatic logic bit_op(input bit_kind_e k, input logic x, input logic y);
    case (k)
      BK_AND:  bit_op = x & y;
      BK_OR:   bit_op = x | y;
      BK_NOR:  bit_op = ~(x | y);
      default: bit_op = x ^ y;
    endcase
  endfunction

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign res[i] = bit_op(kind, opa[i], opb[i]);
  end

endmodule

// File: rtl/lsu_shift.sv
module lsu_shift #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  input  logic              go_right,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] pre_flip;
  logic [DATA_W-1:0] post_flip;
  logic [DATA_W-1:0] stage [SH_W+1];

  // A right shift reuses the left-shift stages by mirroring the word in and out.
  for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
    assign pre_flip[i]  = go_right ? din[DATA_W-1-i] : din[i];
    assign post_flip[i] = stage[SH_W][DATA_W-1-i];
  end

  assign stage[0] = pre_flip;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    assign stage[k+1] = amt[k] ? (stage[k] << (1 << k)) : stage[k];
  end

  assign dout = go_right ? post_flip : stage[SH_W];

endmodule

// File: rtl/logic_shift_unit.sv
module logic_shift_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [SH_W-1:0]   shamt,
  input  logic [OP_W-1:0]   op_code,
  output logic [DATA_W-1:0] result,
  output logic              illegal_op
);

  localparam int PAD_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] zext_const(input logic [IMM_W-1:0] c);
    zext_const = {{PAD_W{1'b0}}, c};
  endfunction

  function automatic logic [DATA_W-1:0] upper_const(input logic [IMM_W-1:0] c);
    upper_const = {c, {PAD_W{1'b0}}};
  endfunction

  // Decode flags, kept as named wires for the checker.
  logic      op_legal;
  logic      op_is_imm;
  logic      op_is_shift;
  logic      op_is_lui;
  logic      shift_right;
  bit_kind_e kind;

  always_comb begin
    op_legal    = 1'b1;
    op_is_imm   = 1'b0;
    op_is_shift = 1'b0;
    op_is_lui   = 1'b0;
    shift_right = 1'b0;
    kind        = BK_AND;
    case (op_code)
      OP_AND:  kind = BK_AND;
      OP_OR:   kind = BK_OR;
      OP_NOR:  kind = BK_NOR;
      OP_XOR:  kind = BK_XOR;
      OP_ANDI: begin kind = BK_AND; op_is_imm = 1'b1; end
      OP_ORI:  begin kind = BK_OR;  op_is_imm = 1'b1; end
      OP_XORI: begin kind = BK_XOR; op_is_imm = 1'b1; end
      OP_SLL:  op_is_shift = 1'b1;
      OP_SRL:  begin op_is_shift = 1'b1; shift_right = 1'b1; end
      OP_LUI:  op_is_lui = 1'b1;
      default: op_legal = 1'b0;
    endcase
  end

  logic [DATA_W-1:0] opb_eff;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] shift_res;
  logic [DATA_W-1:0] lui_res;

  assign opb_eff = op_is_imm ? zext_const(imm16) : src_b;
  assign lui_res = upper_const(imm16);

  lsu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .opa  (src_a),
    .opb  (opb_eff),
    .kind (kind),
    .res  (logic_res)
  );

  lsu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .din      (src_a),
    .amt      (shamt),
    .go_right (shift_right),
    .dout     (shift_res)
  );

  always_comb begin
    if (!op_legal)        result = '0;
    else if (op_is_shift) result = shift_res;
    else if (op_is_lui)   result = lui_res;
    else                  result = logic_res;
  end

  assign illegal_op = ~op_legal;

endmodule

// File: rtl/logic_shift_unit_chk.sv
module logic_shift_unit_chk
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [IMM_W-1:0]  imm16,
  input logic [SH_W-1:0]   shamt,
  input logic [OP_W-1:0]   op_code,
  input logic [DATA_W-1:0] result,
  input logic              illegal_op,
  input logic              op_is_shift
);

  localparam int PAD_W = DATA_W - IMM_W;

  always_comb begin
    AST_OR_NO_CARRY: assert (!(op_code == OP_OR) || ((result & src_a) == src_a && (result & src_b) == src_b)); // R1
    AST_NOR_DISJOINT: assert (!(op_code == OP_NOR) || ((result & (src_a | src_b)) == '0)); // R2
    AST_LUI_UPPER: assert (!(op_code == OP_LUI) || (result[DATA_W-1:PAD_W] == imm16)); // R3
    AST_LUI_LOWER_ZERO: assert (!(op_code == OP_LUI) || (result[PAD_W-1:0] == '0)); // R3
    AST_IMM_AND_HIGH_ZERO: assert (!(op_code == OP_ANDI) || (result[DATA_W-1:IMM_W] == '0)); // R4
    AST_IMM_OR_HIGH_KEEP: assert (!(op_code == OP_ORI) || (result[DATA_W-1:IMM_W] == src_a[DATA_W-1:IMM_W])); // R4
    AST_SRL_TOP_FILL: assert (!(op_code == OP_SRL && shamt != '0) || !result[DATA_W-1]); // R5
    AST_SLL_LOW_FILL: assert (!(op_code == OP_SLL && shamt != '0) || !result[0]); // R6
    AST_ILLEGAL_ZERO: assert (!illegal_op || (result == '0)); // R8
    AST_ILLEGAL_CODES: assert (illegal_op == (op_code > OP_LUI)); // R8
    AST_SHIFT_NO_MOVE: assert (!(op_is_shift && shamt == '0) || (result == src_a)); // R9
  end

endmodule

bind logic_shift_unit logic_shift_unit_chk #(
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W),
  .SH_W   (SH_W)
) u_chk (
  .src_a       (src_a),
  .src_b       (src_b),
  .imm16       (imm16),
  .shamt       (shamt),
  .op_code     (op_code),
  .result      (result),
  .illegal_op  (illegal_op),
  .op_is_shift (op_is_shift)
);

// File: tb/logic_shift_unit_tb.sv
module logic_shift_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  shamt = '0;
  logic [3:0]  op_code = '0;
  logic [31:0] result;
  logic        illegal_op;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  logic_shift_unit u_dut (
    .src_a      (src_a),
    .src_b      (src_b),
    .imm16      (imm16),
    .shamt      (shamt),
    .op_code    (op_code),
    .result     (result),
    .illegal_op (illegal_op)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] c, input logic [4:0] s);
    @(posedge clk);
    op_code = op; src_a = a; src_b = b; imm16 = c; shamt = s;
    @(negedge clk);
  endtask

  // Shift references by arithmetic rather than by shift operators.
  function automatic logic [31:0] ref_left(input logic [31:0] v, input int s);
    longint unsigned p = 1;
    for (int i = 0; i < s; i++) p = p * 2;
    ref_left = 32'(longint'(v) * p);
  endfunction

  function automatic logic [31:0] ref_right(input logic [31:0] v, input int s);
    longint unsigned p = 1;
    for (int i = 0; i < s; i++) p = p * 2;
    ref_right = 32'(longint'(v) / p);
  endfunction

  task automatic t_reset_state();
    drive(4'd0, 32'h0, 32'h0, 16'h0, 5'd0);
    check("R1 idle result", result, 32'h0);
    check("R8 idle flag", {31'b0, illegal_op}, 32'h0);
  endtask

  task automatic t_bitwise();
    drive(4'd1, 32'hD000_0003, 32'h1000_0005, 16'h0, 5'd0);
    check("R1 OR no carry", result, 32'hD000_0007);
    drive(4'd0, 32'hAAAA_AAAA, 32'hFFFF_0000, 16'h0, 5'd0);
    check("R1 AND", result, 32'hAAAA_0000);
    drive(4'd3, 32'hAAAA_AAAA, 32'h5555_5555, 16'h0, 5'd0);
    check("R1 XOR complement", result, 32'hFFFF_FFFF);
    drive(4'd3, 32'h1234_5678, 32'h1234_5678, 16'h0, 5'd0);
    check("R1 XOR equal", result, 32'h0);
    drive(4'd2, 32'h0F00_00F0, 32'h0000_F00F, 16'h0, 5'd0);
    check("R2 NOR", result, ~(32'h0F00_00F0 | 32'h0000_F00F));
    drive(4'd2, 32'h0, 32'h0, 16'h0, 5'd0);
    check("R2 NOR zeros", result, 32'hFFFF_FFFF);
  endtask

  task automatic t_immediate();
    drive(4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h8001, 5'd0);
    check("R4 AND-const zero-extend", result, 32'h0000_8001);
    drive(4'd5, 32'hAB00_0034, 32'hFFFF_FFFF, 16'h895A, 5'd0);
    check("R4 OR-const", result, 32'hAB00_897E);
    drive(4'd6, 32'hF0F0_F0F0, 32'h0, 16'hFFFF, 5'd0);
    check("R4 XOR-const", result, 32'hF0F0_0F0F);
  endtask

  task automatic t_load_upper();
    drive(4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hF7B3, 5'd17);
    check("R3 load-upper", result, 32'hF7B3_0000);
  endtask

  task automatic t_build_constant();
    logic [31:0] hi;
    drive(4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h49B1, 5'd0);
    hi = result;
    drive(4'd5, hi, 32'hFFFF_FFFF, 16'hAE09, 5'd0);
    check("R7 constant pair", result, 32'h49B1_AE09);
  endtask

  task automatic t_shifts();
    drive(4'd8, 32'h0000_0057, 32'h0, 16'h0, 5'd3);
    check("R5 right by 3", result, 32'h0000_000A);
    drive(4'd7, 32'hDEAD_BEEF, 32'h0, 16'h0, 5'd0);
    check("R9 left by 0", result, 32'hDEAD_BEEF);
    drive(4'd8, 32'hDEAD_BEEF, 32'h0, 16'h0, 5'd0);
    check("R9 right by 0", result, 32'hDEAD_BEEF);
    for (int s = 0; s < 32; s++) begin
      drive(4'd7, 32'h8000_0001, 32'hFFFF_FFFF, 16'hFFFF, 5'(s));
      check("R6 left sweep", result, ref_left(32'h8000_0001, s));
      drive(4'd8, 32'h8000_0001, 32'hFFFF_FFFF, 16'hFFFF, 5'(s));
      check("R5 right sweep", result, ref_right(32'h8000_0001, s));
    end
  endtask

  task automatic t_illegal();
    for (int op = 10; op < 16; op++) begin
      drive(4'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd1);
      check("R8 illegal result", result, 32'h0);
      check("R8 illegal flag", {31'b0, illegal_op}, 32'h1);
    end
    for (int op = 0; op < 10; op++) begin
      drive(4'(op), 32'h1, 32'h1, 16'h1, 5'd1);
      check("R8 legal flag", {31'b0, illegal_op}, 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_bitwise();
    t_immediate();
    t_load_upper();
    t_build_constant();
    t_shifts();
    t_illegal();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule